// File: doc/BRIEF.md
# Video Processor Command Port Decoder

This block sits between a host bus and the internal memories of a video display processor. It decodes writes to the control port. A control word carrying the register prefix is a register write and goes straight out on a register bus. Any other control word is half of a two-word access command. The first half is parked until the second half arrives, or both halves come in one 32-bit write. A completed command yields a 6-bit access code and a 16-bit destination address. The code selects one of three memories: video RAM, colour RAM or vertical-scroll RAM.

Data-port reads and writes are passed to the selected memory as byte addresses, already wrapped to that memory's size. After each access the destination address moves on by the auto-increment register. The access code also decides whether a DMA is armed: a video-RAM copy, a memory-to-video-RAM transfer, or a fill that takes its fill word from the next data-port write. A busy flag shows that a DMA is armed, and an external engine reports completion with `dma_done`.

The control path is a two-state machine. `CTL_IDLE` moves to `CTL_HALF` when it latches a first half. `CTL_HALF` returns to `CTL_IDLE` when a command completes, or when a fill capture clears the parked half. A wide command write completes from either state. The DMA machine has four states: `DMA_NONE`, `DMA_MEMORY`, `DMA_COPY` and `DMA_FILL`. An arming event moves it from any state to one of the three active states. `dma_done` moves any active state back to `DMA_NONE`.

Top module: `vdp_cmd_port`

## Requirements
- R1: A control word whose bits 15:14 are binary 10 is a register write. Its index is bits 12:8 and its value is bits 7:0. On the next cycle `reg_we` pulses high for one cycle, with `reg_idx` and `reg_val` holding the index and the value. Index 15 loads the auto-increment. Bit 7 of index 23 is the transfer-hold bit.
- R2: A register write to index 6, 8, 9 or 14 produces no `reg_we` pulse. It changes neither the auto-increment nor the transfer-hold bit.
- R3: A single control word without the register prefix is latched when no half is pending, and `cmd_pending` goes to 1. The next such word completes the command and clears `cmd_pending`. Register writes in between leave the pending half and `cmd_pending` unchanged.
- R4: When `ctl_wide` is set, `ctl_data[31:16]` is the first word and `ctl_data[15:0]` is the second. Such a write completes a command in one cycle, whatever the pending state, and leaves nothing pending. If the upper word carries the register prefix, the write is only that register write.
- R5: On completion, `cmd_code` becomes {second[7:4], first[15:14]} and `dest_addr` becomes {second[1:0], first[13:0]}. Both are visible on the next cycle.
- R6: `mem_sel` is 0 (video RAM) when `cmd_code & 0x0E` is 0. It is 2 (vertical-scroll RAM) when that value is 4. It is 1 (colour RAM) for every other value.
- R7: `mem_addr0` is `dest_addr` modulo the selected memory's size, and `mem_addr1` is (`dest_addr`+1) modulo that size. The sizes are 65536, 128 and 80 bytes.
- R8: A data write that is not a fill capture drives `mem_we` in the same cycle. A data read with no write drives `mem_re`; a write takes priority over a read in the same cycle. Each such access adds the auto-increment to `dest_addr` on the next cycle, modulo 2^16.
- R9: A command that completes with code bits 5 and 4 both set arms a copy (`dma_kind` 2).
- R10: A command that completes with code bit 5 set and bit 4 clear arms a memory transfer (`dma_kind` 1), but only while the transfer-hold bit is 0.
- R11: While `cmd_code[5:4]` is binary 10, a data write is a fill capture. `mem_we` stays low, `fill_word` takes the written value, `dest_addr` is unchanged and `dma_kind` becomes 3. Any pending half is cleared, unless a control word that changes the latch arrives in the same cycle.
- R12: `dma_busy` is 1 exactly while `dma_kind` is not 0. `dma_done` returns both to 0, but an arming event in the same cycle takes priority.
- R13: A data access and a control write in the same cycle are handled in order. The data access uses the code, address and increment from before that cycle, and the control write is applied after it. A command that completes in that cycle sets the address, overriding the increment.
- R14: After reset, `cmd_pending`, `cmd_code`, `dest_addr`, `dma_kind`, `dma_busy`, `fill_word` and `reg_we` are all 0, and video RAM is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control-port write strobe |
| ctl_wide | input | 1 | Write carries two words (32 bits) |
| ctl_data | input | 32 | Control word(s); a single word uses bits 15:0 |
| dat_we | input | 1 | Data-port write strobe |
| dat_re | input | 1 | Data-port read strobe |
| dat_wdata | input | 16 | Data-port write value |
| dma_done | input | 1 | External DMA engine finished |
| cmd_pending | output | 1 | First command half is parked |
| cmd_code | output | 6 | Current access code |
| dest_addr | output | 16 | Current destination address |
| mem_sel | output | 2 | Selected memory: 0 video, 1 colour, 2 vertical-scroll |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr0 | output | 16 | Wrapped address of the first byte |
| mem_addr1 | output | 16 | Wrapped address of the second byte |
| mem_wdata | output | 16 | Write data to memory (big-endian pair) |
| fill_word | output | 16 | Captured fill value |
| dma_kind | output | 2 | 0 none, 1 memory, 2 copy, 3 fill |
| dma_busy | output | 1 | A DMA is armed |
| reg_we | output | 1 | Register write pulse to neighbours |
| reg_idx | output | 5 | Register index |
| reg_val | output | 8 | Register value |

## Verification
A data-port access can fall in the same cycle as a control write. The interesting cases are an access beside a second command half that reloads the address, an access beside a write to the increment register, and a fill capture beside a new first half. The bench drives these overlaps on purpose and mixes them into a long random stretch. Its behavioural model applies the data access first, using the state from before the cycle, and then the control write. Address, pending flag and DMA kind are compared on every clock. A design that lets the control write act first diverges within one cycle.

// File: rtl/vdp_cmd_pkg.sv
package vdp_cmd_pkg;

    typedef enum logic [1:0] {
        TGT_VRAM  = 2'd0,
        TGT_CRAM  = 2'd1,
        TGT_VSRAM = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        DMA_NONE   = 2'd0,
        DMA_MEMORY = 2'd1,
        DMA_COPY   = 2'd2,
        DMA_FILL   = 2'd3
    } dma_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_HALF = 1'b1
    } ctl_e;

    localparam logic [1:0] REG_PREFIX  = 2'b10;
    localparam logic [4:0] REG_AUTOINC = 5'd15;
    localparam logic [4:0] REG_SRC_HI  = 5'd23;

    function automatic tgt_e tgt_of(input logic [2:0] code_mid);
        tgt_e t;
        unique case (code_mid)
            3'd0:    t = TGT_VRAM;
            3'd2:    t = TGT_VSRAM;
            default: t = TGT_CRAM;
        endcase
        return t;
    endfunction

    function automatic logic reg_ignored(input logic [4:0] idx);
        return (idx == 5'd6) || (idx == 5'd8) || (idx == 5'd9) || (idx == 5'd14);
    endfunction

endpackage

// File: rtl/vdp_ctl_fsm.sv
module vdp_ctl_fsm
    import vdp_cmd_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic                ctl_wide,
    input  logic [2*WORD_W-1:0] ctl_data,
    input  logic                fill_take,
    output logic                reg_hit,
    output logic [4:0]          reg_idx,
    output logic [7:0]          reg_val,
    output logic                cmd_done,
    output logic [5:0]          new_code,
    output logic [15:0]         new_addr,
    output logic                pending
);

    ctl_e              state_q, state_d;
    logic [WORD_W-1:0] held_q;
    logic [WORD_W-1:0] word_hi, first_w, second_w;
    logic              cmd_word, latch;
    logic              unused_bits;

    assign word_hi  = ctl_wide ? ctl_data[2*WORD_W-1:WORD_W] : ctl_data[WORD_W-1:0];
    assign reg_hit  = ctl_we && (word_hi[15:14] == REG_PREFIX);
    assign reg_idx  = word_hi[12:8];
    assign reg_val  = word_hi[7:0];
    assign cmd_word = ctl_we && !reg_hit;
    assign first_w  = ctl_wide ? ctl_data[2*WORD_W-1:WORD_W] : held_q;
    assign second_w = ctl_data[WORD_W-1:0];
    assign new_code = {second_w[7:4], first_w[15:14]};
    assign new_addr = {second_w[1:0], first_w[13:0]};
    assign pending  = (state_q == CTL_HALF);
    assign unused_bits = ^{second_w[15:8], second_w[3:2], word_hi[13], first_w[WORD_W-1:16]};

    always_comb begin
        state_d  = state_q;
        cmd_done = 1'b0;
        latch    = 1'b0;
        unique case (state_q)
            CTL_IDLE: begin
                if (cmd_word) begin
                    if (ctl_wide) begin
                        cmd_done = 1'b1;
                    end else begin
                        latch   = 1'b1;
                        state_d = CTL_HALF;
                    end
                end
            end
            CTL_HALF: begin
                if (cmd_word) begin
                    cmd_done = 1'b1;
                    state_d  = CTL_IDLE;
                end else if (fill_take) begin
                    state_d = CTL_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (latch) held_q <= ctl_data[WORD_W-1:0];
        end
    end

endmodule

// File: rtl/vdp_dest_addr.sv
module vdp_dest_addr
    import vdp_cmd_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int INC_W       = 8,
    parameter int VRAM_BYTES  = 65536,
    parameter int CRAM_BYTES  = 128,
    parameter int VSRAM_BYTES = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic [INC_W-1:0]  inc,
    input  tgt_e              tgt,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] wrap0,
    output logic [ADDR_W-1:0] wrap1
);

    localparam int LIM_W = ADDR_W + 1;

    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] next_byte;

    always_comb begin
        unique case (tgt)
            TGT_CRAM:  limit = LIM_W'(CRAM_BYTES);
            TGT_VSRAM: limit = LIM_W'(VSRAM_BYTES);
            default:   limit = LIM_W'(VRAM_BYTES);
        endcase
    end

    assign next_byte = {1'b0, addr_q} + LIM_W'(1);
    assign wrap0     = ADDR_W'({1'b0, addr_q} % limit);
    assign wrap1     = ADDR_W'(next_byte % limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(inc);
        end
    end

endmodule

// File: rtl/vdp_dma_arm.sv
module vdp_dma_arm
    import vdp_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_done,
    input  logic [1:0] code_hi,
    input  logic       src_hold,
    input  logic       fill_take,
    input  logic       dma_done,
    output dma_e       kind_q,
    output logic       busy_q
);

    dma_e kind_d;
    logic arm;

    always_comb begin
        unique case (kind_q)
            DMA_NONE:                      kind_d = DMA_NONE;
            DMA_MEMORY, DMA_COPY, DMA_FILL: kind_d = dma_done ? DMA_NONE : kind_q;
        endcase
        arm = 1'b1;
        if (cmd_done && code_hi[1] && code_hi[0]) begin
            kind_d = DMA_COPY;
        end else if (cmd_done && code_hi[1] && !src_hold) begin
            kind_d = DMA_MEMORY;
        end else if (fill_take) begin
            kind_d = DMA_FILL;
        end else begin
            arm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= DMA_NONE;
            busy_q <= 1'b0;
        end else begin
            kind_q <= kind_d;
            if (arm) busy_q <= 1'b1;
            else if (dma_done) busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/vdp_cmd_port.sv
module vdp_cmd_port
    import vdp_cmd_pkg::*;
#(
    parameter int VRAM_BYTES  = 65536,
    parameter int CRAM_BYTES  = 128,
    parameter int VSRAM_BYTES = 80
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic        ctl_wide,
    input  logic [31:0] ctl_data,
    input  logic        dat_we,
    input  logic        dat_re,
    input  logic [15:0] dat_wdata,
    input  logic        dma_done,
    output logic        cmd_pending,
    output logic [5:0]  cmd_code,
    output logic [15:0] dest_addr,
    output logic [1:0]  mem_sel,
    output logic        mem_we,
    output logic        mem_re,
    output logic [15:0] mem_addr0,
    output logic [15:0] mem_addr1,
    output logic [15:0] mem_wdata,
    output logic [15:0] fill_word,
    output logic [1:0]  dma_kind,
    output logic        dma_busy,
    output logic        reg_we,
    output logic [4:0]  reg_idx,
    output logic [7:0]  reg_val
);

    localparam int WORD_W = 16;
    localparam int ADDR_W = 16;
    localparam int INC_W  = 8;

    logic              reg_hit, cmd_done, fill_take;
    logic [4:0]        hit_idx;
    logic [7:0]        hit_val;
    logic [5:0]        new_code, code_q;
    logic [ADDR_W-1:0] new_addr;
    logic [INC_W-1:0]  inc_q;
    logic              src_hold_q;
    logic [15:0]       fill_q;
    logic              reg_we_q;
    logic [4:0]        reg_idx_q;
    logic [7:0]        reg_val_q;
    tgt_e              tgt;
    dma_e              kind;

    assign fill_take = dat_we && (code_q[5:4] == 2'b10);
    assign mem_we    = dat_we && !fill_take;
    assign mem_re    = dat_re && !dat_we;
    assign tgt       = tgt_of(code_q[3:1]);

    vdp_ctl_fsm #(.WORD_W(WORD_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wide  (ctl_wide),
        .ctl_data  (ctl_data),
        .fill_take (fill_take),
        .reg_hit   (reg_hit),
        .reg_idx   (hit_idx),
        .reg_val   (hit_val),
        .cmd_done  (cmd_done),
        .new_code  (new_code),
        .new_addr  (new_addr),
        .pending   (cmd_pending)
    );

    vdp_dest_addr #(
        .ADDR_W      (ADDR_W),
        .INC_W       (INC_W),
        .VRAM_BYTES  (VRAM_BYTES),
        .CRAM_BYTES  (CRAM_BYTES),
        .VSRAM_BYTES (VSRAM_BYTES)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_done),
        .load_val (new_addr),
        .step     (mem_we || mem_re),
        .inc      (inc_q),
        .tgt      (tgt),
        .addr_q   (dest_addr),
        .wrap0    (mem_addr0),
        .wrap1    (mem_addr1)
    );

    vdp_dma_arm u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_done  (cmd_done),
        .code_hi   (new_code[5:4]),
        .src_hold  (src_hold_q),
        .fill_take (fill_take),
        .dma_done  (dma_done),
        .kind_q    (kind),
        .busy_q    (dma_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q     <= '0;
            inc_q      <= '0;
            src_hold_q <= 1'b0;
            fill_q     <= '0;
            reg_we_q   <= 1'b0;
            reg_idx_q  <= '0;
            reg_val_q  <= '0;
        end else begin
            reg_we_q <= 1'b0;
            if (reg_hit && !reg_ignored(hit_idx)) begin
                reg_we_q  <= 1'b1;
                reg_idx_q <= hit_idx;
                reg_val_q <= hit_val;
                if (hit_idx == REG_AUTOINC) inc_q      <= hit_val;
                if (hit_idx == REG_SRC_HI)  src_hold_q <= hit_val[7];
            end
            if (cmd_done)  code_q <= new_code;
            if (fill_take) fill_q <= dat_wdata;
        end
    end

    assign cmd_code  = code_q;
    assign mem_sel   = tgt;
    assign mem_wdata = dat_wdata;
    assign fill_word = fill_q;
    assign dma_kind  = kind;
    assign reg_we    = reg_we_q;
    assign reg_idx   = reg_idx_q;
    assign reg_val   = reg_val_q;

endmodule

// File: rtl/vdp_cmd_port_chk.sv
module vdp_cmd_port_chk #(
    parameter int CRAM_BYTES  = 128,
    parameter int VSRAM_BYTES = 80
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we,
    input logic        ctl_wide,
    input logic [31:0] ctl_data,
    input logic        dat_we,
    input logic        dat_re,
    input logic        cmd_pending,
    input logic [5:0]  cmd_code,
    input logic [15:0] dest_addr,
    input logic [1:0]  mem_sel,
    input logic [15:0] mem_addr0,
    input logic [15:0] mem_addr1,
    input logic [1:0]  dma_kind,
    input logic        dma_busy,
    input logic        reg_we,
    input logic [7:0]  inc_q
);

    logic [15:0] stepped;
    logic        single_reg;
    logic        single_cmd;
    logic [4:0]  single_idx;

    assign stepped    = dest_addr + 16'(inc_q);
    assign single_reg = ctl_we && !ctl_wide && (ctl_data[15:14] == 2'b10);
    assign single_cmd = ctl_we && !ctl_wide && (ctl_data[15:14] != 2'b10);
    assign single_idx = ctl_data[12:8];

    p_ignored_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (single_reg && (single_idx == 5'd6 || single_idx == 5'd8 ||
                        single_idx == 5'd9 || single_idx == 5'd14)) |=> !reg_we);

    p_reg_keeps_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (single_reg && !dat_we) |=> (cmd_pending == $past(cmd_pending)));

    p_second_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && single_cmd) |=> !cmd_pending);

    p_wrap_vsram_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel == 2'd2) |-> (mem_addr0 < 16'(VSRAM_BYTES) && mem_addr1 < 16'(VSRAM_BYTES)));

    p_wrap_cram_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel == 2'd1) |-> (mem_addr0 < 16'(CRAM_BYTES) && mem_addr1 < 16'(CRAM_BYTES)));

    p_read_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_re && !dat_we && !ctl_we) |=> (dest_addr == $past(stepped)));

    p_fill_holds_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && cmd_code[5:4] == 2'b10 && !ctl_we) |=>
            (dest_addr == $past(dest_addr) && dma_kind == 2'd3));

    p_busy_tracks_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy == (dma_kind != 2'd0));

endmodule

bind vdp_cmd_port vdp_cmd_port_chk #(
    .CRAM_BYTES  (CRAM_BYTES),
    .VSRAM_BYTES (VSRAM_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_wide    (ctl_wide),
    .ctl_data    (ctl_data),
    .dat_we      (dat_we),
    .dat_re      (dat_re),
    .cmd_pending (cmd_pending),
    .cmd_code    (cmd_code),
    .dest_addr   (dest_addr),
    .mem_sel     (mem_sel),
    .mem_addr0   (mem_addr0),
    .mem_addr1   (mem_addr1),
    .dma_kind    (dma_kind),
    .dma_busy    (dma_busy),
    .reg_we      (reg_we),
    .inc_q       (inc_q)
);

// File: tb/test_vdp_cmd_port.sv
`timescale 1ns/1ps
module test_vdp_cmd_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, ctl_wide = 1'b0;
    logic [31:0] ctl_data = '0;
    logic        dat_we = 1'b0, dat_re = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic        dma_done = 1'b0;
    logic        cmd_pending;
    logic [5:0]  cmd_code;
    logic [15:0] dest_addr;
    logic [1:0]  mem_sel;
    logic        mem_we, mem_re;
    logic [15:0] mem_addr0, mem_addr1, mem_wdata, fill_word;
    logic [1:0]  dma_kind;
    logic        dma_busy, reg_we;
    logic [4:0]  reg_idx;
    logic [7:0]  reg_val;

    always #2.5 clk = ~clk;

    vdp_cmd_port i_vdp_cmd_port (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wide(ctl_wide), .ctl_data(ctl_data),
        .dat_we(dat_we), .dat_re(dat_re), .dat_wdata(dat_wdata), .dma_done(dma_done),
        .cmd_pending(cmd_pending), .cmd_code(cmd_code), .dest_addr(dest_addr),
        .mem_sel(mem_sel), .mem_we(mem_we), .mem_re(mem_re), .mem_addr0(mem_addr0),
        .mem_addr1(mem_addr1), .mem_wdata(mem_wdata), .fill_word(fill_word),
        .dma_kind(dma_kind), .dma_busy(dma_busy), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_val(reg_val)
    );

    int    n_chk = 0, n_fail = 0;
    string cur = "R14";

    // behavioural reference state
    bit        m_pend;
    bit [15:0] m_held;
    bit [5:0]  m_code;
    int        m_addr;
    int        m_inc;
    bit        m_hold;
    bit [15:0] m_fill;
    int        m_kind;
    bit        m_rwe;
    bit [4:0]  m_ridx;
    bit [7:0]  m_rval;

    function automatic int sel_of(bit [5:0] c);
        int v = c & 6'h0E;
        if (v == 0) return 0;
        if (v == 4) return 2;
        return 1;
    endfunction

    function automatic int size_of(bit [5:0] c);
        int s = sel_of(c);
        if (s == 0) return 65536;
        if (s == 2) return 80;
        return 128;
    endfunction

    task automatic chk(string f, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", cur, f, act, exp);
        end
    endtask

    task automatic cyc(bit cwe, bit cwide, bit [31:0] cd, bit dwe, bit dre, bit [15:0] dw, bit done);
        bit        fill, acc, isreg, cmdw, fin;
        bit [15:0] w, first, second;
        bit [4:0]  idx;
        ctl_we = cwe; ctl_wide = cwide; ctl_data = cd;
        dat_we = dwe; dat_re = dre; dat_wdata = dw; dma_done = done;
        #1;
        fill = dwe && (m_code[5:4] == 2'b10);
        chk("mem_we", mem_we, dwe && !fill);
        chk("mem_re", mem_re, dre && !dwe);
        chk("mem_sel", mem_sel, sel_of(m_code));
        chk("mem_addr0", mem_addr0, m_addr % size_of(m_code));
        chk("mem_addr1", mem_addr1, (m_addr + 1) % size_of(m_code));
        chk("mem_wdata", mem_wdata, dw);
        @(posedge clk);
        // data side first, with pre-cycle state
        acc = (dwe && !fill) || (dre && !dwe);
        if (acc) m_addr = (m_addr + m_inc) % 65536;
        if (fill) m_fill = dw;
        // control side
        w = cwide ? cd[31:16] : cd[15:0];
        isreg = cwe && (w[15:14] == 2'b10);
        cmdw = cwe && !isreg;
        idx = w[12:8];
        m_rwe = 1'b0;
        if (isreg && !(idx == 6 || idx == 8 || idx == 9 || idx == 14)) begin
            m_rwe = 1'b1; m_ridx = idx; m_rval = w[7:0];
            if (idx == 15) m_inc = w[7:0];
            if (idx == 23) m_hold = w[7];
        end
        fin = 1'b0; first = 16'h0;
        second = cd[15:0];
        if (cmdw) begin
            if (cwide) begin fin = 1'b1; first = cd[31:16]; end
            else if (m_pend) begin fin = 1'b1; first = m_held; end
            else begin m_pend = 1'b1; m_held = cd[15:0]; end
        end else if (fill) begin
            m_pend = 1'b0;
        end
        if (fin) begin
            m_code = {second[7:4], first[15:14]};
            m_addr = {second[1:0], first[13:0]};
            m_pend = 1'b0;
        end
        if (fin && m_code[5] && m_code[4]) m_kind = 2;
        else if (fin && m_code[5] && !m_hold) m_kind = 1;
        else if (fill) m_kind = 3;
        else if (done) m_kind = 0;
        @(negedge clk);
        chk("cmd_pending", cmd_pending, m_pend);
        chk("cmd_code", cmd_code, m_code);
        chk("dest_addr", dest_addr, m_addr);
        chk("fill_word", fill_word, m_fill);
        chk("dma_kind", dma_kind, m_kind);
        chk("dma_busy", dma_busy, m_kind != 0);
        chk("reg_we", reg_we, m_rwe);
        if (m_rwe) begin
            chk("reg_idx", reg_idx, m_ridx);
            chk("reg_val", reg_val, m_rval);
        end
    endtask

    task automatic idle();             cyc(0, 0, 0, 0, 0, 0, 0); endtask
    task automatic cw(bit [15:0] w);   cyc(1, 0, {16'h0, w}, 0, 0, 0, 0); endtask
    task automatic wide(bit [31:0] d); cyc(1, 1, d, 0, 0, 0, 0); endtask
    task automatic regw(bit [4:0] i, bit [7:0] v); cw({3'b100, i, v}); endtask
    task automatic dwr(bit [15:0] v);  cyc(0, 0, 0, 1, 0, v, 0); endtask
    task automatic drd();              cyc(0, 0, 0, 0, 1, 0, 0); endtask
    task automatic done();             cyc(0, 0, 0, 0, 0, 0, 1); endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #500us;
        n_chk++; n_fail++;
        $display("FAIL R14 watchdog expired: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        m_pend = 0; m_held = 0; m_code = 0; m_addr = 0; m_inc = 0; m_hold = 0;
        m_fill = 0; m_kind = 0; m_rwe = 0; m_ridx = 0; m_rval = 0;
        repeat (3) @(negedge clk);
        cur = "R14";
        chk("cmd_pending", cmd_pending, 0);
        chk("cmd_code", cmd_code, 0);
        chk("dest_addr", dest_addr, 0);
        chk("dma_kind", dma_kind, 0);
        chk("dma_busy", dma_busy, 0);
        chk("fill_word", fill_word, 0);
        chk("reg_we", reg_we, 0);
        chk("mem_sel", mem_sel, 0);
        rst_n = 1'b1;
        idle();

        cur = "R1";
        regw(5'd5, 8'h3C);
        regw(5'd15, 8'h02);
        chk("inc via reg_val", reg_val, 8'h02);

        cur = "R2";
        regw(5'd6, 8'h11); regw(5'd8, 8'h22); regw(5'd9, 8'h33); regw(5'd14, 8'h44);
        regw(5'd14, 8'h80);
        idle();

        cur = "R3";
        cw(16'h7ABC);
        regw(5'd1, 8'h55);
        chk("pending kept", cmd_pending, 1);
        cw(16'h0003);
        chk("assembled addr", dest_addr, 16'hFABC);

        cur = "R5";
        cw(16'hC000); cw(16'h0000);
        cur = "R6";
        chk("cram select", mem_sel, 1);
        cw(16'h4000); cw(16'h0010);
        chk("vsram select", mem_sel, 2);
        cw(16'h0000); cw(16'h0030);
        chk("code 0C select", mem_sel, 1);

        cur = "R7";
        cw(16'h404F); cw(16'h0010); idle();
        cw(16'h40C8); cw(16'h0010); idle();
        cw(16'hC07F); cw(16'h0000); idle();
        cw(16'h7FFF); cw(16'h0003); idle();

        cur = "R8";
        cw(16'h4010); cw(16'h0000);
        dwr(16'hBEEF); dwr(16'h1234); drd();
        cyc(0, 0, 0, 1, 1, 16'h5555, 0);
        regw(5'd15, 8'h00); dwr(16'h0001); drd();
        regw(5'd15, 8'hFF); drd(); drd();

        cur = "R4";
        wide(32'h4123_0002);
        cw(16'h4001);
        wide(32'h8000_0000 | 32'h0F04_0000 | 32'h0000_4444);
        wide(32'h0000_0000);

        cur = "R9";
        cw(16'h0000); cw(16'h00C0);
        chk("copy armed", dma_kind, 2);
        cur = "R12";
        idle(); done(); idle();

        cur = "R10";
        cw(16'h0000); cw(16'h0080);
        chk("memory armed", dma_kind, 1);
        done();
        regw(5'd23, 8'h80);
        cw(16'h0000); cw(16'h0080);
        chk("held: no arm", dma_kind, 0);

        cur = "R11";
        cw(16'h1234);
        dwr(16'hA5A5);
        chk("fill word", fill_word, 16'hA5A5);
        chk("fill clears half", cmd_pending, 0);
        done();

        cur = "R13";
        regw(5'd15, 8'h04);
        cw(16'h4000);
        cyc(1, 0, 32'h0000_0000, 1, 0, 16'h0101, 0);
        cyc(1, 0, 32'h0000_8F10, 1, 0, 16'h0202, 0);
        drd();
        cw(16'h0000); cw(16'h0080);
        cyc(1, 0, 32'h0000_4321, 1, 0, 16'h7777, 0);
        chk("latch beats fill clear", cmd_pending, 1);
        cw(16'h0000);
        cur = "R12";
        regw(5'd23, 8'h00);
        cw(16'h0000);
        cyc(1, 0, 32'h0000_00C0, 0, 0, 0, 1);
        chk("arm beats done", dma_kind, 2);
        done();

        cur = "R13";
        for (int i = 0; i < 600; i++) begin
            bit [31:0] d;
            bit        cwe, cwd;
            d = $urandom;
            case ($urandom_range(0, 3))
                0: d[15:14] = 2'b10;
                1: d[15:8]  = 8'h8F;
                default: ;
            endcase
            if ($urandom_range(0, 7) == 0) d[31:24] = 8'h97;
            cwe = ($urandom_range(0, 2) == 0);
            cwd = ($urandom_range(0, 4) == 0);
            cyc(cwe, cwd, d, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                16'($urandom), $urandom_range(0, 7) == 0);
        end

        summary();
        $finish;
    end

endmodule